// File: doc/BRIEF.md
# Occupancy Limit Tuner for a Miss-Handling Structure

This block decides how many entries a miss-handling structure may keep in use at once. It does this by trial and selection. A training phase runs the structure at three candidate limits in turn: the whole capacity, half of it and a quarter of it. Each candidate runs for a programmable number of cycles. During each trial the block adds up the committed micro-operation increments that every core reports.

When the third trial ends, the block picks the candidate that produced the largest total. It holds that limit for a programmable epoch, and then starts training again. The miss-handling structure reads the published limit. The block also gives it an allocation-permit signal built from the current occupancy. Lowering the limit never removes entries that are already held. It only refuses new allocations while occupancy is at or above the limit.

Top module: `occ_limit_tuner`

## Requirements
- R1: `entry_limit` is always one of three values: `max_cap`, `max_cap >> 1` or `max_cap >> 2` (shifts round down). Each value is computed from the present `max_cap`.
- R2: Training runs trials in a fixed order: `trial_idx` 0 (full), then 1 (half), then 2 (quarter). Each trial lasts exactly `trial_len` cycles, and a value of 0 acts as 1. During trial k, `training` is 1 and `entry_limit` equals `max_cap >> k`.
- R3: A trial's score is the sum, over every clock edge of that trial, of all per-core increments. Core i's increment is the unsigned field `commit_inc[i*INC_W +: INC_W]`. The score is cleared when each trial starts. The accumulator cannot overflow, even at the largest increment on every core for the longest trial.
- R4: After trial 2 the block enters the epoch. `training` becomes 0 and `trial_idx` reads 0. The limit of the highest-scoring trial is held for exactly `epoch_len` cycles, and a value of 0 acts as 1. Training then restarts at trial 0.
- R5: When scores are equal, the trial with the larger limit (the lower index) wins.
- R6: Increments that arrive during the epoch have no effect on the next selection.
- R7: `alloc_ok` is 1 exactly when `occupancy < entry_limit`. When the limit falls below the current occupancy, nothing else happens: only new allocations are refused.
- R8: While `rst_n` is low, the block shows this state: `training` = 1, `trial_idx` = 0 and `entry_limit` = `max_cap`. A trial-0 interval starts on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_inc | input | NCORES*INC_W | Per-core committed micro-op increments, packed one field per core |
| max_cap | input | CAP_W | Maximum entry count of the structure |
| trial_len | input | LEN_W | Cycles per trial (0 behaves as 1) |
| epoch_len | input | EPOCH_W | Cycles the chosen limit is held (0 behaves as 1) |
| occupancy | input | CAP_W | Entries currently in use in the structure |
| entry_limit | output | CAP_W | Active occupancy limit |
| alloc_ok | output | 1 | New allocation permitted |
| training | output | 1 | 1 in the training phase, 0 in the epoch |
| trial_idx | output | 2 | Trial in progress (0 full, 1 half, 2 quarter); reads 0 in the epoch |

## Verification
Some properties are checked by assertions on every cycle:
- the limit is always one of the three fractions and never exceeds the capacity;
- the phase and trial index move only along the allowed order;
- the limit stays stable within an epoch;
- allocation is refused at or above the limit.

Other behaviours only the bench's scenarios can show:
- exact trial and epoch durations, including the zero-length settings;
- the selected winner under increasing, flat, tied and per-core-varying increment patterns;
- the absence of accumulator overflow at saturation;
- that epoch-time increments are ignored.

// File: rtl/olt_pkg.sv
// Shared definitions for the occupancy limit tuner.
// Assumes exactly three candidate limits: full, half and quarter capacity.
package olt_pkg;

    typedef enum logic {
        PH_EPOCH = 1'b0,
        PH_TRAIN = 1'b1
    } phase_e;

    localparam int        NUM_TRIALS  = 3;
    localparam logic [1:0] TRIAL_FIRST = 2'd0;
    localparam logic [1:0] TRIAL_FINAL = 2'd2;

endpackage

// File: rtl/olt_sequencer.sv
// Phase and trial sequencer.
// Walks through trial 0, 1 and 2 for trial_len cycles each, then holds
// an epoch of epoch_len cycles. It assumes the length inputs stay
// stable while an interval is running. A zero length behaves as one.
module olt_sequencer
    import olt_pkg::*;
#(
    parameter int LEN_W   = 10,
    parameter int EPOCH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEN_W-1:0]   trial_len,
    input  logic [EPOCH_W-1:0] epoch_len,
    output phase_e             phase_o,
    output logic [1:0]         idx_o,
    output logic               trial_done_o
);

    localparam int CNT_W = ((LEN_W > EPOCH_W) ? LEN_W : EPOCH_W) + 1;

    phase_e           phase_q;
    logic [1:0]       idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             trial_done;
    logic             epoch_done;

    // Detect the final cycle of the running trial or epoch.
    always_comb begin
        cnt_nxt    = cnt_q + CNT_W'(1);
        trial_done = (phase_q == PH_TRAIN) && (cnt_nxt >= CNT_W'(trial_len));
        epoch_done = (phase_q == PH_EPOCH) && (cnt_nxt >= CNT_W'(epoch_len));
    end

    // Advance the phase, the trial index and the interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_TRAIN;
            idx_q   <= TRIAL_FIRST;
            cnt_q   <= '0;
        end else if (phase_q == PH_TRAIN) begin
            if (trial_done) begin
                cnt_q <= '0;
                if (idx_q == TRIAL_FINAL) begin
                    phase_q <= PH_EPOCH;
                    idx_q   <= TRIAL_FIRST;
                end else begin
                    idx_q <= idx_q + 2'd1;
                end
            end else begin
                cnt_q <= cnt_nxt;
            end
        end else begin
            if (epoch_done) begin
                phase_q <= PH_TRAIN;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    assign phase_o      = phase_q;
    assign idx_o        = idx_q;
    assign trial_done_o = trial_done;

endmodule

// File: rtl/olt_accum.sv
// Trial score accumulator.
// Adds the increments of all cores on each training cycle. total_o is
// the running score including the current cycle, so it holds the final
// trial total on the last cycle of a trial. ACC_W must cover the
// longest trial at the maximum increment on every core.
module olt_accum
    import olt_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int INC_W  = 3,
    parameter int ACC_W  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES*INC_W-1:0] commit_inc,
    input  phase_e                  phase,
    input  logic                    trial_done,
    output logic [ACC_W-1:0]        total_o
);

    logic [INC_W-1:0] lane [NCORES];
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] cycle_sum;

    // Split the packed increment bus into one lane per core.
    for (genvar g = 0; g < NCORES; g++) begin : g_lane
        assign lane[g] = commit_inc[g*INC_W +: INC_W];
    end

    // Sum this cycle's lanes and add the sum to the running score.
    always_comb begin
        cycle_sum = '0;
        for (int i = 0; i < NCORES; i++) begin
            cycle_sum = cycle_sum + ACC_W'(lane[i]);
        end
        total_o = acc_q + cycle_sum;
    end

    // Accumulate during a trial; clear at each trial boundary and in the epoch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (phase != PH_TRAIN || trial_done) begin
            acc_q <= '0;
        end else begin
            acc_q <= total_o;
        end
    end

endmodule

// File: rtl/olt_select.sv
// Best-trial selector.
// Records the best score and its trial index at the end of each trial.
// Trial 0 always seeds the record. A later trial replaces it only with
// a strictly larger score, so ties keep the larger limit.
module olt_select #(
    parameter int ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trial_done,
    input  logic [1:0]       idx,
    input  logic [ACC_W-1:0] total,
    output logic [1:0]       win_o
);

    logic [ACC_W-1:0] best_q;
    logic [1:0]       win_q;

    // Update the best score and the winning index at the close of a trial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q <= '0;
            win_q  <= '0;
        end else if (trial_done && (idx == 2'd0 || total > best_q)) begin
            best_q <= total;
            win_q  <= idx;
        end
    end

    assign win_o = win_q;

endmodule

// File: rtl/occ_limit_tuner.sv
// Occupancy limit tuner (top).
// Publishes the active entry limit for a miss-handling structure: the
// trial candidate during training, the winner during the epoch. It also
// gates new allocations against that limit. It assumes max_cap is
// static over a period.
module occ_limit_tuner
    import olt_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int INC_W   = 3,
    parameter int CAP_W   = 6,
    parameter int LEN_W   = 10,
    parameter int EPOCH_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES*INC_W-1:0] commit_inc,
    input  logic [CAP_W-1:0]        max_cap,
    input  logic [LEN_W-1:0]        trial_len,
    input  logic [EPOCH_W-1:0]      epoch_len,
    input  logic [CAP_W-1:0]        occupancy,
    output logic [CAP_W-1:0]        entry_limit,
    output logic                    alloc_ok,
    output logic                    training,
    output logic [1:0]              trial_idx
);

    localparam int ACC_W = INC_W + $clog2(NCORES) + LEN_W;

    phase_e           phase;
    logic [1:0]       idx;
    logic [1:0]       win;
    logic             trial_done;
    logic [ACC_W-1:0] total;
    logic [CAP_W-1:0] cand [NUM_TRIALS];
    logic [1:0]       sel;

    olt_sequencer #(
        .LEN_W   (LEN_W),
        .EPOCH_W (EPOCH_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .trial_len    (trial_len),
        .epoch_len    (epoch_len),
        .phase_o      (phase),
        .idx_o        (idx),
        .trial_done_o (trial_done)
    );

    olt_accum #(
        .NCORES (NCORES),
        .INC_W  (INC_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_inc (commit_inc),
        .phase      (phase),
        .trial_done (trial_done),
        .total_o    (total)
    );

    olt_select #(
        .ACC_W (ACC_W)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .trial_done (trial_done),
        .idx        (idx),
        .total      (total),
        .win_o      (win)
    );

    // Candidate k is the capacity divided by 2**k.
    for (genvar k = 0; k < NUM_TRIALS; k++) begin : g_cand
        assign cand[k] = max_cap >> k;
    end

    // Choose the limit source by phase and gate allocation on it.
    always_comb begin
        sel = (phase == PH_TRAIN) ? idx : win;
        case (sel)
            2'd1:    entry_limit = cand[1];
            2'd2:    entry_limit = cand[2];
            default: entry_limit = cand[0];
        endcase
        alloc_ok = occupancy < entry_limit;
    end

    assign training  = (phase == PH_TRAIN);
    assign trial_idx = idx;

endmodule

// File: rtl/occ_limit_tuner_chk.sv
// Property checker for occ_limit_tuner, attached with bind.
// Watches only the ports of the top module.
module occ_limit_tuner_chk #(
    parameter int CAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CAP_W-1:0] max_cap,
    input logic [CAP_W-1:0] occupancy,
    input logic [CAP_W-1:0] entry_limit,
    input logic             alloc_ok,
    input logic             training,
    input logic [1:0]       trial_idx
);

    p_limit_fraction_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_limit == max_cap) || (entry_limit == (max_cap >> 1)) ||
        (entry_limit == (max_cap >> 2)));

    p_limit_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        entry_limit <= max_cap);

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trial_idx != 2'd3);

    p_from_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (training && trial_idx == 2'd0) |=> (training && trial_idx <= 2'd1));

    p_from_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (training && trial_idx == 2'd1) |=> (training && (trial_idx == 2'd1 || trial_idx == 2'd2)));

    p_from_quarter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (training && trial_idx == 2'd2) |=> (!training || trial_idx == 2'd2));

    p_epoch_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !training |=> (trial_idx == 2'd0));

    p_epoch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!training && $past(!training) && $stable(max_cap)) |-> $stable(entry_limit));

    p_alloc_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy >= entry_limit) |-> !alloc_ok);

    p_alloc_allow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy < entry_limit) |-> alloc_ok);

endmodule

bind occ_limit_tuner occ_limit_tuner_chk #(
    .CAP_W (CAP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .max_cap     (max_cap),
    .occupancy   (occupancy),
    .entry_limit (entry_limit),
    .alloc_ok    (alloc_ok),
    .training    (training),
    .trial_idx   (trial_idx)
);

// File: tb/occ_limit_tuner_tb_top.sv
// Self-checking bench: sweeps increment patterns, lengths and
// capacities, and computes the winner of each period arithmetically.
module occ_limit_tuner_tb_top;

    localparam int NC = 4;
    localparam int IW = 3;
    localparam int CW = 6;
    localparam int LW = 10;
    localparam int EW = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC*IW-1:0] commit_inc = '0;
    logic [CW-1:0]    max_cap = '0;
    logic [LW-1:0]    trial_len = '0;
    logic [EW-1:0]    epoch_len = '0;
    logic [CW-1:0]    occupancy = '0;
    logic [CW-1:0]    entry_limit;
    logic             alloc_ok;
    logic             training;
    logic [1:0]       trial_idx;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    occ_limit_tuner #(
        .NCORES  (NC),
        .INC_W   (IW),
        .CAP_W   (CW),
        .LEN_W   (LW),
        .EPOCH_W (EW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_inc  (commit_inc),
        .max_cap     (max_cap),
        .trial_len   (trial_len),
        .epoch_len   (epoch_len),
        .occupancy   (occupancy),
        .entry_limit (entry_limit),
        .alloc_ok    (alloc_ok),
        .training    (training),
        .trial_idx   (trial_idx)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Apply a random occupancy and check the allocation permit.
    task automatic drive_occ();
        occupancy = CW'($urandom_range(0, (1 << CW) - 1));
        #1;
        check("R7 alloc_ok", alloc_ok, (occupancy < entry_limit) ? 1 : 0);
    endtask

    // R8: synchronous reset with a new configuration.
    task automatic do_reset(input int cap, input int tl, input int el);
        rst_n      = 1'b0;
        max_cap    = CW'(cap);
        trial_len  = LW'(tl);
        epoch_len  = EW'(el);
        commit_inc = '0;
        repeat (2) @(negedge clk);
        check("R8 training", training, 1);
        check("R8 trial_idx", trial_idx, 0);
        check("R8 entry_limit", entry_limit, cap);
        rst_n = 1'b1;
    endtask

    // One full period. On entry the last posedge seen was the start of
    // trial 0. mode 0: all cores get base b[t]; mode 1: per-core mixed
    // values. dent lowers core 0 by one on trial 0's last cycle.
    task automatic run_period(input int b0, input int b1, input int b2,
                              input int mode, input int dent, input string tag);
        int      base [3];
        longint  sums [3];
        int      l_eff;
        int      e_eff;
        int      win;
        longint  best;
        base[0] = b0; base[1] = b1; base[2] = b2;
        l_eff = (trial_len == 0) ? 1 : int'(trial_len);
        e_eff = (epoch_len == 0) ? 1 : int'(epoch_len);
        for (int t = 0; t < 3; t++) begin
            sums[t] = 0;
            for (int c = 0; c < l_eff; c++) begin
                check("R2 training", training, 1);
                check("R2 trial_idx", trial_idx, t);
                check("R1 R2 entry_limit", entry_limit, int'(max_cap) >> t);
                for (int k = 0; k < NC; k++) begin
                    int v;
                    if (mode == 1) v = (base[t] * 3 + k * 5 + c * 7) % 8;
                    else           v = base[t];
                    if (dent != 0 && t == 0 && k == 0 && c == l_eff - 1 && v > 0) v = v - 1;
                    commit_inc[k*IW +: IW] = IW'(v);
                    sums[t] += v;
                end
                drive_occ();
                @(negedge clk);
            end
        end
        win  = 0;
        best = sums[0];
        for (int t = 1; t < 3; t++) begin
            if (sums[t] > best) begin
                best = sums[t];
                win  = t;
            end
        end
        for (int c = 0; c < e_eff; c++) begin
            check("R4 training", training, 0);
            check("R4 trial_idx", trial_idx, 0);
            check({tag, " R3 R4 R5 winner limit"}, entry_limit, int'(max_cap) >> win);
            // R6: large epoch increments must not sway the next period.
            for (int k = 0; k < NC; k++) begin
                commit_inc[k*IW +: IW] = IW'($urandom_range(4, 7));
            end
            drive_occ();
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // Scenario A: capacity 40, trials of 5, epoch of 7.
        do_reset(40, 5, 7);
        run_period(1, 2, 3, 0, 0, "A quarter wins");
        run_period(3, 3, 3, 0, 0, "A R5 three-way tie");
        run_period(2, 5, 5, 0, 0, "A R5 half-quarter tie");
        run_period(6, 1, 2, 0, 0, "A R6 full wins after epoch noise");
        run_period(2, 4, 7, 1, 0, "A mixed lanes");
        run_period(5, 0, 1, 1, 0, "A mixed lanes 2");
        // Scenario B: single-cycle trials and epoch.
        do_reset(63, 1, 1);
        run_period(0, 0, 1, 0, 0, "B quarter wins");
        run_period(4, 1, 1, 0, 0, "B full wins");
        run_period(0, 0, 0, 0, 0, "B R5 all zero");
        // Scenario C: zero lengths behave as one cycle.
        do_reset(9, 0, 0);
        run_period(1, 2, 0, 0, 0, "C R2 zero length");
        run_period(0, 1, 3, 0, 0, "C R4 zero epoch");
        // Scenario D: longest trial at full rate, R3 overflow margin.
        do_reset(32, 1023, 3);
        run_period(7, 7, 7, 0, 1, "D R3 saturation half wins");
        run_period(7, 6, 7, 0, 0, "D R3 saturation full ties quarter");
        finish_run();
    end

endmodule